// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits between the receive path of an Ethernet MAC and its receive DMA. It decides, frame by frame, whether a frame is kept. The destination octets are fed in one at a time in wire order. When the frame ends, the block is given the frame length and a done strobe. One clock later it returns exactly one of two single-cycle pulses: accept or drop.

The frame length is checked against a programmable ceiling before any address test. The destination is then classed as broadcast (all ones), multicast (first octet bit 0 set, not all ones) or unicast. A unicast frame is kept only when it matches the 48-bit station address. Broadcast and multicast each have their own reject bit and their own force-accept bit, and the force-accept bit wins.

A small write port loads five configuration words: two station-address words, the reject word, the force-accept word and the length ceiling.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset the length ceiling is 0x600, the force-accept word is 0x3FFFF (bits 9 and 8 set), the reject word is 0 and the station address is all zeros, and neither output pulses.
- R2: For every done strobe, exactly one of `accept_o` / `drop_o` is high for one cycle, in the cycle after the strobe; with no strobe, both stay low.
- R3: A frame whose length is greater than the low 16 bits of the ceiling is dropped whatever its destination; a length equal to the ceiling passes the length test.
- R4: A broadcast destination FF:FF:FF:FF:FF:FF is accepted when force-accept bit 9 is set; otherwise it is dropped exactly when reject bit 9 is set.
- R5: A multicast destination is accepted when force-accept bit 8 is set; otherwise it is dropped exactly when reject bit 8 is set.
- R6: Broadcast decisions ignore bit 8 and multicast decisions ignore bit 9; an all-ones destination is treated as broadcast even though its first octet has bit 0 set.
- R7: A unicast destination is accepted only when all six octets equal the station address. Octet 1 is word A bits 31:24, octet 2 bits 23:16, octet 3 bits 15:8, octet 4 bits 7:0, octet 5 word B bits 31:24, octet 6 word B bits 23:16. Word B bits 15:0 have no effect.
- R8: A frame that ends with fewer than six destination octets is dropped; octets beyond the sixth do not affect the decision.
- R9: A write with `cfg_sel_i` = 0 loads station word A, 1 loads word B, 2 the reject word, 3 the force-accept word and 4 the length ceiling, of which only bits 15:0 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration word select (0..4) |
| cfg_wdata_i | input | 32 | Configuration write data |
| oct_valid_i | input | 1 | Destination octet valid |
| oct_data_i | input | 8 | Destination octet, wire order |
| frame_len_i | input | 16 | Frame length, valid with done strobe |
| frame_done_i | input | 1 | End-of-frame strobe |
| accept_o | output | 1 | Frame accepted pulse |
| drop_o | output | 1 | Frame dropped pulse |

## Verification
The classifier is tried with broadcast, group-bit multicast, matching unicast and unicast that differs only in the first or last octet. These tell apart a full six-octet compare from a partial one. Each class is paired with every mix of its own reject and force-accept bits and with the other class's bits, which exposes swapped bit positions and a wrong precedence. Lengths at the ceiling and one above it, a reprogrammed ceiling with junk in its upper half, and short and over-long destination runs separate the length gate and the octet counter from the address logic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int unsigned CFG_SEL_W = 3;

   localparam logic [CFG_SEL_W-1:0] SEL_STN_A   = 3'd0;
   localparam logic [CFG_SEL_W-1:0] SEL_STN_B   = 3'd1;
   localparam logic [CFG_SEL_W-1:0] SEL_REJECT  = 3'd2;
   localparam logic [CFG_SEL_W-1:0] SEL_FORCE   = 3'd3;
   localparam logic [CFG_SEL_W-1:0] SEL_MAXLEN  = 3'd4;

   typedef enum logic [1:0] {
      DST_NONE  = 2'd0,
      DST_UNI   = 2'd1,
      DST_MULTI = 2'd2,
      DST_BCAST = 2'd3
   } dst_class_e;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
   import rxf_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned LEN_W      = 16,
   parameter int unsigned BC_BIT     = 9,
   parameter int unsigned MC_BIT     = 8,
   parameter logic [LEN_W-1:0]  MAXLEN_RST = 16'h0600,
   parameter logic [WORD_W-1:0] FORCE_RST  = 32'h0003_FFFF,
   localparam int unsigned STN_W = WORD_W + 16
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 we_i,
   input  logic [CFG_SEL_W-1:0] sel_i,
   input  logic [WORD_W-1:0]    wdata_i,
   output logic [STN_W-1:0]     station_o,
   output logic                 rej_bc_o,
   output logic                 rej_mc_o,
   output logic                 frc_bc_o,
   output logic                 frc_mc_o,
   output logic [LEN_W-1:0]     max_len_o
);
   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("rxf_cfg_regs: WORD_W must be 32");
      end
      if (BC_BIT >= WORD_W || MC_BIT >= WORD_W || BC_BIT == MC_BIT) begin : g_bad_bits
         $error("rxf_cfg_regs: control bit positions invalid");
      end
      if (LEN_W > WORD_W) begin : g_bad_len
         $error("rxf_cfg_regs: LEN_W exceeds WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] stn_a_q, stn_b_q, rej_q, frc_q;
   logic [LEN_W-1:0]  max_len_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stn_a_q   <= '0;
         stn_b_q   <= '0;
         rej_q     <= '0;
         frc_q     <= FORCE_RST;
         max_len_q <= MAXLEN_RST;
      end else if (we_i) begin
         unique case (sel_i)
            SEL_STN_A:  stn_a_q   <= wdata_i;
            SEL_STN_B:  stn_b_q   <= wdata_i;
            SEL_REJECT: rej_q     <= wdata_i;
            SEL_FORCE:  frc_q     <= wdata_i;
            SEL_MAXLEN: max_len_q <= wdata_i[LEN_W-1:0];
            default: ;
         endcase
      end
   end

   assign station_o = {stn_a_q, stn_b_q[WORD_W-1 -: 16]};
   assign rej_bc_o  = rej_q[BC_BIT];
   assign rej_mc_o  = rej_q[MC_BIT];
   assign frc_bc_o  = frc_q[BC_BIT];
   assign frc_mc_o  = frc_q[MC_BIT];
   assign max_len_o = max_len_q;

   // R9: ceiling write keeps only the low length bits
   a_r9_maxlen_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == SEL_MAXLEN) |=> (max_len_o == $past(wdata_i[LEN_W-1:0])));
   // R9: a write to another word leaves the ceiling alone
   a_r9_maxlen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(we_i && sel_i == SEL_MAXLEN)) |=> $stable(max_len_o));
endmodule

// File: rtl/rxf_dest_scan.sv
module rxf_dest_scan
   import rxf_pkg::*;
#(
   parameter int unsigned OCT_W   = 8,
   parameter int unsigned N_OCT   = 6,
   localparam int unsigned STN_W  = OCT_W * N_OCT,
   localparam int unsigned CNT_W  = $clog2(N_OCT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [STN_W-1:0] station_i,
   input  logic             oct_valid_i,
   input  logic [OCT_W-1:0] oct_data_i,
   input  logic             frame_done_i,
   output dst_class_e       dst_class_o,
   output logic             uc_hit_o
);
   generate
      if (N_OCT < 2) begin : g_bad_n
         $error("rxf_dest_scan: N_OCT must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_OCT);

   // station octets in wire order, octet 0 being the most significant
   logic [OCT_W-1:0] stn_oct [N_OCT];
   genvar gi;
   generate
      for (gi = 0; gi < N_OCT; gi++) begin : g_oct
         assign stn_oct[gi] = station_i[STN_W-1-gi*OCT_W -: OCT_W];
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             ones_q, match_q, group_q;
   logic             take;
   logic [OCT_W-1:0] exp_oct;

   assign take    = oct_valid_i && (cnt_q < LAST);
   assign exp_oct = (cnt_q < LAST) ? stn_oct[cnt_q[CNT_W-1:0]] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         ones_q  <= 1'b1;
         match_q <= 1'b1;
         group_q <= 1'b0;
      end else if (frame_done_i) begin
         cnt_q   <= '0;
         ones_q  <= 1'b1;
         match_q <= 1'b1;
         group_q <= 1'b0;
      end else if (take) begin
         cnt_q   <= cnt_q + 1'b1;
         ones_q  <= ones_q  & (&oct_data_i);
         match_q <= match_q & (oct_data_i == exp_oct);
         if (cnt_q == '0) group_q <= oct_data_i[0];
      end
   end

   logic full;
   assign full = (cnt_q == LAST);

   always_comb begin
      if (!full)        dst_class_o = DST_NONE;
      else if (ones_q)  dst_class_o = DST_BCAST;
      else if (group_q) dst_class_o = DST_MULTI;
      else              dst_class_o = DST_UNI;
   end
   assign uc_hit_o = full && match_q;

   // R8: the octet counter never runs past the address length
   a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);
   // R8: a full counter does not move until the frame ends
   a_r8_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full && !frame_done_i) |=> full);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  dst_class_e       dst_class_i,
   input  logic             uc_hit_i,
   input  logic             rej_bc_i,
   input  logic             rej_mc_i,
   input  logic             frc_bc_i,
   input  logic             frc_mc_i,
   input  logic [LEN_W-1:0] max_len_i,
   input  logic [LEN_W-1:0] frame_len_i,
   input  logic             frame_done_i,
   output logic             accept_o,
   output logic             drop_o
);
   logic len_ok, addr_ok, keep;

   assign len_ok = (frame_len_i <= max_len_i);

   always_comb begin
      unique case (dst_class_i)
         DST_BCAST: addr_ok = frc_bc_i | ~rej_bc_i;
         DST_MULTI: addr_ok = frc_mc_i | ~rej_mc_i;
         DST_UNI:   addr_ok = uc_hit_i;
         default:   addr_ok = 1'b0;
      endcase
   end

   assign keep = len_ok && addr_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         accept_o <= 1'b0;
         drop_o   <= 1'b0;
      end else begin
         accept_o <= frame_done_i &  keep;
         drop_o   <= frame_done_i & ~keep;
      end
   end

   // R2: never both outcomes at once
   a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({accept_o, drop_o}));
   // R2: an outcome only follows a done strobe
   a_r2_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o || drop_o) |-> $past(frame_done_i));
   // R2: every done strobe is answered next cycle
   a_r2_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done_i |=> (accept_o || drop_o));
   // R3: an over-long frame is always dropped
   a_r3_oversize: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_done_i && frame_len_i > max_len_i) |=> drop_o);
   // R8: an incomplete destination is always dropped
   a_r8_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_done_i && dst_class_i == DST_NONE) |=> drop_o);
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
   import rxf_pkg::*;
#(
   parameter int unsigned OCT_W      = 8,
   parameter int unsigned LEN_W      = 16,
   parameter int unsigned BC_BIT     = 9,
   parameter int unsigned MC_BIT     = 8,
   parameter logic [15:0] MAXLEN_RST = 16'h0600,
   parameter logic [31:0] FORCE_RST  = 32'h0003_FFFF
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cfg_we_i,
   input  logic [CFG_SEL_W-1:0] cfg_sel_i,
   input  logic [31:0]          cfg_wdata_i,
   input  logic                 oct_valid_i,
   input  logic [OCT_W-1:0]     oct_data_i,
   input  logic [LEN_W-1:0]     frame_len_i,
   input  logic                 frame_done_i,
   output logic                 accept_o,
   output logic                 drop_o
);
   localparam int unsigned N_OCT = 6;
   localparam int unsigned STN_W = OCT_W * N_OCT;

   generate
      if (OCT_W != 8) begin : g_bad_oct
         $error("rxf_addr_filter: OCT_W must be 8");
      end
      if (LEN_W != 16) begin : g_bad_len
         $error("rxf_addr_filter: LEN_W must be 16");
      end
   endgenerate

   logic [STN_W-1:0] station;
   logic             rej_bc, rej_mc, frc_bc, frc_mc;
   logic [LEN_W-1:0] max_len;
   dst_class_e       dst_class;
   logic             uc_hit;

   rxf_cfg_regs #(
      .WORD_W     (32),
      .LEN_W      (LEN_W),
      .BC_BIT     (BC_BIT),
      .MC_BIT     (MC_BIT),
      .MAXLEN_RST (MAXLEN_RST[LEN_W-1:0]),
      .FORCE_RST  (FORCE_RST)
   ) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (cfg_we_i),
      .sel_i     (cfg_sel_i),
      .wdata_i   (cfg_wdata_i),
      .station_o (station),
      .rej_bc_o  (rej_bc),
      .rej_mc_o  (rej_mc),
      .frc_bc_o  (frc_bc),
      .frc_mc_o  (frc_mc),
      .max_len_o (max_len)
   );

   rxf_dest_scan #(
      .OCT_W (OCT_W),
      .N_OCT (N_OCT)
   ) u_scan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .station_i    (station),
      .oct_valid_i  (oct_valid_i),
      .oct_data_i   (oct_data_i),
      .frame_done_i (frame_done_i),
      .dst_class_o  (dst_class),
      .uc_hit_o     (uc_hit)
   );

   rxf_decide #(
      .LEN_W (LEN_W)
   ) u_dec (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .dst_class_i  (dst_class),
      .uc_hit_i     (uc_hit),
      .rej_bc_i     (rej_bc),
      .rej_mc_i     (rej_mc),
      .frc_bc_i     (frc_bc),
      .frc_mc_i     (frc_mc),
      .max_len_i    (max_len),
      .frame_len_i  (frame_len_i),
      .frame_done_i (frame_done_i),
      .accept_o     (accept_o),
      .drop_o       (drop_o)
   );
endmodule

// File: tb/rxf_addr_filter_tb.sv
module rxf_addr_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        oct_valid = 1'b0;
   logic [7:0]  oct_data = '0;
   logic [15:0] frame_len = '0;
   logic        frame_done = 1'b0;
   logic        accept, drop;

   int n_chk = 0;
   int n_bad = 0;
   bit timed_out = 1'b0;

   always #5 clk = ~clk;

   rxf_addr_filter u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cfg_we_i     (cfg_we),
      .cfg_sel_i    (cfg_sel),
      .cfg_wdata_i  (cfg_wdata),
      .oct_valid_i  (oct_valid),
      .oct_data_i   (oct_data),
      .frame_len_i  (frame_len),
      .frame_done_i (frame_done),
      .accept_o     (accept),
      .drop_o       (drop)
   );

   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCAST = 48'h0100_5E00_0001;
   localparam logic [47:0] STN   = 48'h0211_2233_4455;

   // {dest, len, reject[9:8], force[9:8], expect_accept}
   localparam int NV = 15;
   localparam logic [68:0] VEC [NV] = '{
      {BCAST, 16'd64,    2'b00, 2'b00, 1'b1},  // R4
      {BCAST, 16'd64,    2'b10, 2'b00, 1'b0},  // R4
      {BCAST, 16'd64,    2'b10, 2'b10, 1'b1},  // R4
      {BCAST, 16'd64,    2'b01, 2'b00, 1'b1},  // R6
      {MCAST, 16'd64,    2'b01, 2'b00, 1'b0},  // R5
      {MCAST, 16'd64,    2'b01, 2'b01, 1'b1},  // R5
      {MCAST, 16'd64,    2'b10, 2'b00, 1'b1},  // R6
      {MCAST, 16'd64,    2'b00, 2'b00, 1'b1},  // R5
      {STN,   16'd64,    2'b11, 2'b00, 1'b1},  // R7
      {48'h0211_2233_4456, 16'd64, 2'b00, 2'b00, 1'b0}, // R7
      {48'h0011_2233_4455, 16'd64, 2'b00, 2'b00, 1'b0}, // R7
      {BCAST, 16'h0601,  2'b00, 2'b00, 1'b0},  // R3
      {STN,   16'h0600,  2'b00, 2'b00, 1'b1},  // R3
      {BCAST, 16'h0700,  2'b00, 2'b11, 1'b0},  // R3
      {48'hFFFF_FFFF_FFFE, 16'd64, 2'b01, 2'b00, 1'b0}  // R6
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // sends n octets of dest (wire order), then done; checks outcome and pulse width
   task automatic send(input logic [47:0] dest, input int n, input logic [15:0] len,
                       input bit exp_acc, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         oct_valid = 1'b1;
         oct_data  = (i < 6) ? dest[47-8*i -: 8] : 8'hA5;
      end
      @(negedge clk);
      oct_valid = 1'b0;
      check(!accept && !drop, "R2", "idle before done", {accept, drop}, 0);
      frame_done = 1'b1; frame_len = len;
      @(negedge clk);
      frame_done = 1'b0;
      check(accept == exp_acc && drop == !exp_acc, req, "outcome {acc,drop}",
            {accept, drop}, {exp_acc, !exp_acc});
      @(negedge clk);
      check(!accept && !drop, "R2", "single-cycle pulse", {accept, drop}, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      timed_out = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(!accept && !drop, "R1", "outputs in reset", {accept, drop}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!accept && !drop, "R1", "outputs after reset", {accept, drop}, 0);

      // R1: reset defaults observed through decisions
      cfg_write(3'd2, 32'h0000_0300);           // reject bits set, force still at reset
      send(BCAST, 6, 16'h0600, 1'b1, "R1");
      send(MCAST, 6, 16'h0600, 1'b1, "R1");
      send(BCAST, 6, 16'h0601, 1'b0, "R1");
      send(48'h0, 6, 16'd64, 1'b1, "R1");        // station resets to zero

      // table walk, station word B low half carries junk (R7)
      cfg_write(3'd0, 32'h0211_2233);
      cfg_write(3'd1, 32'h4455_ABCD);
      for (int v = 0; v < NV; v++) begin
         logic [68:0] e;
         string tag;
         e = VEC[v];
         cfg_write(3'd2, {22'b0, e[4:3], 8'b0});
         cfg_write(3'd3, {22'b0, e[2:1], 8'b0});
         tag = $sformatf("R4-7 vec%0d", v);
         send(e[68:21], 6, e[20:5], e[0], tag);
      end

      cfg_write(3'd2, 32'h0);
      cfg_write(3'd3, 32'h0);
      // R8: short destination, then over-long destination
      send(STN, 5, 16'd64, 1'b0, "R8");
      send(STN, 9, 16'd64, 1'b1, "R8");
      send(BCAST, 0, 16'd64, 1'b0, "R8");

      // R9: ceiling reprogrammed, upper half of write ignored
      cfg_write(3'd4, 32'hFFFF_0040);
      send(STN, 6, 16'h0040, 1'b1, "R9");
      send(STN, 6, 16'h0041, 1'b0, "R9");
      // R9: reject word write drops broadcast now that force is clear
      cfg_write(3'd2, 32'h0000_0200);
      send(BCAST, 6, 16'd10, 1'b0, "R9");
      cfg_write(3'd3, 32'h0000_0200);
      send(BCAST, 6, 16'd10, 1'b1, "R9");

      // R2: back-to-back frames each answered
      send(STN, 6, 16'd20, 1'b1, "R2");
      send(48'h0211_2233_4400, 6, 16'd20, 1'b0, "R2");

      if (!timed_out) begin
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule